// File: doc/BRIEF.md
# Per-Channel Gamma Correction Table

This block applies a programmable transfer curve to the pixels leaving a compositor with several output channels. Every colour component (red, green, blue) of every channel is used as an index into its own 256-entry table, and the 8-bit value found there replaces the component on the way out. All tables live in one shared storage array. A simple register port with two registers fills and inspects that array: a pointer register and a data register. When the pointer's step flag is set, each data access moves the pointer forward by one entry, so a whole channel can be streamed in with back-to-back data writes.

Each channel has its own gamma enable input. When it is low, that channel's components come out unchanged, which gives the same result as an identity table. The lookup has one registered stage: a component presented with its channel's valid strobe appears on the output one clock later, together with a delayed valid.

Software writes the pointer with the channel's base entry and the step flag set. It then writes the red curve, the green curve and the blue curve in that order, and finally raises the channel's gamma enable.

Top module: `gamma_lut`

## Requirements
- R1: A synchronous active-low reset clears the pointer to entry 0, clears the step flag and drops every output valid. Reading the pointer register then returns 16'h0000.
- R2: The table entry for channel c, component k (red 0, green 1, blue 2) and index i is found at entry c*768 + k*256 + i. On the pixel buses, component k of channel c occupies bits [(c*3+k)*8 +: 8].
- R3: When the step flag is set, a data register write stores wdata[7:0] at the pointer, and the pointer then moves to the next entry.
- R4: When the step flag is clear, a data register write stores at the pointer and leaves the pointer unchanged.
- R5: A data register read returns the entry at the pointer in the same cycle as the read strobe. It advances the pointer only when the step flag is set.
- R6: With gamma enabled for a channel, a valid component produces the table entry it indexes one clock later. The channel's output valid is the input valid delayed by one clock.
- R7: With gamma disabled for a channel, a valid component is passed to the output unchanged one clock later, whatever the table holds.
- R8: When a data write and a lookup hit the same entry in the same cycle, the lookup returns the value that was stored before the write. The next lookup returns the new value.
- R9: A stepping access at the last entry (2303) wraps the pointer to entry 0.
- R10: The pointer register holds the entry number in bits [11:0] and the step flag in bit 15. Writing it loads both fields. Bits [14:12] are dropped and read back as 0.
- R11: While a channel's input valid is low, its output components hold their last value and its output valid is low.
- R12: A data access whose pointer is 2304 or above stores nothing and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 pointer, 1 data |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value, combinational from the current state |
| gamma_en | input | 3 | Per-channel table enable |
| pix_valid | input | 3 | Per-channel input component valid |
| pix_in | input | 72 | Input components, 3 channels × R,G,B × 8 bits |
| pix_valid_out | output | 3 | Per-channel output valid, one clock after pix_valid |
| pix_out | output | 72 | Corrected components, same layout as pix_in |

## Verification
The checker assumes that reg_wr and reg_rd are never high in the same cycle. The pointer properties depend on that, because the port defines no order between the two strobes. The bench issues exactly one strobe per access and leaves a quiet cycle after each one. The checker also assumes that pix_valid is low while reset is held. The bench drives every input to zero before it releases reset. In the pixel properties, the input values are taken in the cycle of the valid strobe, and the bench changes inputs only on falling edges so that each value is stable across the sampling edge.

// File: rtl/gamma_lut_pkg.sv
// Package: shared constants and table layout arithmetic for the gamma table.
// Assumes components are numbered red 0, green 1, blue 2.
package gamma_lut_pkg;

    localparam int unsigned COMP_NUM = 3;

    // First entry of the curve for channel ch, component comp, with 2**idx_bits entries per curve.
    function automatic int unsigned curve_base(input int unsigned ch,
                                               input int unsigned comp,
                                               input int unsigned idx_bits);
        return (ch * COMP_NUM + comp) << idx_bits;
    endfunction

endpackage

// File: rtl/gamma_lut_port.sv
// Module: programming port. It holds the pointer register and its step flag,
// decodes data accesses into table writes, and forms the read value.
// Assumes reg_wr and reg_rd are never high together.
module gamma_lut_port #(
    parameter int unsigned REG_W       = 16,
    parameter int unsigned STEP_BIT    = 15,
    parameter int unsigned COMP_W      = 8,
    parameter int unsigned DEPTH       = 2304,
    parameter int unsigned ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [COMP_W-1:0] tbl_rdata,
    output logic              tbl_we,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [COMP_W-1:0] tbl_wdata,
    output logic              step_flag
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic              step_q;
    logic [ADDR_W-1:0] ptr_next;
    logic              data_acc;
    logic              in_range;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign data_acc     = reg_sel && (reg_wr || reg_rd);
    assign in_range     = (ptr_q <= LAST);
    assign ptr_next     = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

    // Pointer and step flag: loaded by a pointer write, advanced by a stepping data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            step_q <= 1'b0;
        end else if (reg_wr && !reg_sel) begin
            ptr_q  <= reg_wdata[ADDR_W-1:0];
            step_q <= reg_wdata[STEP_BIT];
        end else if (data_acc && step_q) begin
            ptr_q  <= ptr_next;
        end
    end

    // Table write request: only for data writes that land inside the table.
    always_comb begin
        tbl_we    = reg_wr && reg_sel && in_range;
        tbl_addr  = ptr_q;
        tbl_wdata = reg_wdata[COMP_W-1:0];
        step_flag = step_q;
    end

    // Read value: the table entry for the data register, the packed fields for the pointer register.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            if (in_range)
                reg_rdata[COMP_W-1:0] = tbl_rdata;
        end else begin
            reg_rdata[ADDR_W-1:0] = ptr_q;
            reg_rdata[STEP_BIT]   = step_q;
        end
    end

endmodule

// File: rtl/gamma_lut_store.sv
// Module: shared table storage with one write port, one read port for the
// programming side and NRD combinational read ports for the lookups.
// Assumes the writer only presents addresses below DEPTH. Contents are not reset.
module gamma_lut_store #(
    parameter int unsigned DEPTH  = 2304,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned NRD    = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [COMP_W-1:0]        wdata,
    output logic [COMP_W-1:0]        port_rdata,
    input  logic [NRD*ADDR_W-1:0]    lk_addr,
    output logic [NRD*COMP_W-1:0]    lk_data
);

    logic [COMP_W-1:0] mem [DEPTH];

    // Storage write: one entry per cycle from the programming port.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Programming read: same address as the write port, guarded against out-of-range pointers.
    assign port_rdata = (waddr < ADDR_W'(DEPTH)) ? mem[waddr] : '0;

    // Lookup reads, one per channel component.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign lk_data[r*COMP_W +: COMP_W] = mem[lk_addr[r*ADDR_W +: ADDR_W]];
    end

endmodule

// File: rtl/gamma_lut_path.sv
// Module: lookup datapath. It forms the table address for each component,
// selects between the table value and the raw input per channel, and registers
// the result for one cycle of latency. Assumes the component width equals the index width.
module gamma_lut_path #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic [NUM_CH-1:0]                                 gamma_en,
    input  logic [NUM_CH-1:0]                                 pix_valid,
    input  logic [NUM_CH*gamma_lut_pkg::COMP_NUM*COMP_W-1:0]  pix_in,
    output logic [NUM_CH*gamma_lut_pkg::COMP_NUM*ADDR_W-1:0]  lk_addr,
    input  logic [NUM_CH*gamma_lut_pkg::COMP_NUM*COMP_W-1:0]  lk_data,
    output logic [NUM_CH-1:0]                                 pix_valid_out,
    output logic [NUM_CH*gamma_lut_pkg::COMP_NUM*COMP_W-1:0]  pix_out
);

    localparam int unsigned NC   = gamma_lut_pkg::COMP_NUM;
    localparam int unsigned CH_W = NC * COMP_W;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic            vld_q;
        logic [CH_W-1:0] out_q;
        logic [CH_W-1:0] sel_d;

        for (genvar k = 0; k < NC; k++) begin : g_comp
            localparam int unsigned SLOT = c * NC + k;
            localparam logic [ADDR_W-1:0] BASE =
                ADDR_W'(gamma_lut_pkg::curve_base(c, k, COMP_W));
            // Table address: curve base plus component value.
            assign lk_addr[SLOT*ADDR_W +: ADDR_W] =
                BASE + ADDR_W'(pix_in[SLOT*COMP_W +: COMP_W]);
            // Per-channel choice between the looked-up value and the raw component.
            assign sel_d[k*COMP_W +: COMP_W] = gamma_en[c] ?
                lk_data[SLOT*COMP_W +: COMP_W] : pix_in[SLOT*COMP_W +: COMP_W];
        end

        // Output stage: capture on valid, hold otherwise, delay valid by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                out_q <= '0;
            end else begin
                vld_q <= pix_valid[c];
                if (pix_valid[c])
                    out_q <= sel_d;
            end
        end

        assign pix_valid_out[c]           = vld_q;
        assign pix_out[c*CH_W +: CH_W]    = out_q;
    end

endmodule

// File: rtl/gamma_lut.sv
// Module: top of the per-channel gamma table. It joins the programming port,
// the shared storage and the lookup datapath. Assumes one register strobe per cycle.
module gamma_lut #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned COMP_W   = 8,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned STEP_BIT = 15
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             reg_wr,
    input  logic                                             reg_rd,
    input  logic                                             reg_sel,
    input  logic [REG_W-1:0]                                 reg_wdata,
    output logic [REG_W-1:0]                                 reg_rdata,
    input  logic [NUM_CH-1:0]                                gamma_en,
    input  logic [NUM_CH-1:0]                                pix_valid,
    input  logic [NUM_CH*gamma_lut_pkg::COMP_NUM*COMP_W-1:0] pix_in,
    output logic [NUM_CH-1:0]                                pix_valid_out,
    output logic [NUM_CH*gamma_lut_pkg::COMP_NUM*COMP_W-1:0] pix_out
);

    localparam int unsigned NRD    = NUM_CH * gamma_lut_pkg::COMP_NUM;
    localparam int unsigned DEPTH  = NRD * (1 << COMP_W);
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic                     tbl_we;
    logic [ADDR_W-1:0]        cur_addr;
    logic [COMP_W-1:0]        tbl_wdata;
    logic [COMP_W-1:0]        tbl_rdata;
    logic                     cur_step;
    logic [NRD*ADDR_W-1:0]    lk_addr;
    logic [NRD*COMP_W-1:0]    lk_data;

    gamma_lut_port #(
        .REG_W(REG_W), .STEP_BIT(STEP_BIT), .COMP_W(COMP_W),
        .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tbl_rdata(tbl_rdata), .tbl_we(tbl_we), .tbl_addr(cur_addr),
        .tbl_wdata(tbl_wdata), .step_flag(cur_step)
    );

    gamma_lut_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .COMP_W(COMP_W), .NRD(NRD)
    ) u_store (
        .clk(clk), .we(tbl_we), .waddr(cur_addr), .wdata(tbl_wdata),
        .port_rdata(tbl_rdata), .lk_addr(lk_addr), .lk_data(lk_data)
    );

    gamma_lut_path #(
        .NUM_CH(NUM_CH), .COMP_W(COMP_W), .ADDR_W(ADDR_W)
    ) u_path (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en), .pix_valid(pix_valid),
        .pix_in(pix_in), .lk_addr(lk_addr), .lk_data(lk_data),
        .pix_valid_out(pix_valid_out), .pix_out(pix_out)
    );

endmodule

// File: rtl/gamma_lut_chk.sv
// Module: property checker for gamma_lut, attached by bind. It observes the
// pointer state and the pixel ports. Assumes a single register strobe per cycle.
module gamma_lut_chk #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 2304
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic                       reg_sel,
    input logic [ADDR_W-1:0]          cur_addr,
    input logic                       cur_step,
    input logic [NUM_CH-1:0]          gamma_en,
    input logic [NUM_CH-1:0]          pix_valid,
    input logic [NUM_CH*3*COMP_W-1:0] pix_in,
    input logic [NUM_CH-1:0]          pix_valid_out,
    input logic [NUM_CH*3*COMP_W-1:0] pix_out
);

    localparam int unsigned CH_W = 3 * COMP_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && !cur_step && pix_valid_out == '0));

    p_step_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && cur_step && cur_addr != LAST)
        |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    p_hold_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && (reg_wr || reg_rd) && !cur_step) |=> $stable(cur_addr));

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && (reg_wr || reg_rd) && cur_step && cur_addr == LAST)
        |=> cur_addr == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> pix_valid_out[c] == $past(pix_valid[c]));

        p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pix_valid[c]) && !$past(gamma_en[c]))
            |-> pix_out[c*CH_W +: CH_W] == $past(pix_in[c*CH_W +: CH_W]));

        p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(pix_valid[c]))
            |-> $stable(pix_out[c*CH_W +: CH_W]));
    end

endmodule

bind gamma_lut gamma_lut_chk #(
    .NUM_CH(NUM_CH), .COMP_W(COMP_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .cur_addr(cur_addr), .cur_step(cur_step), .gamma_en(gamma_en),
    .pix_valid(pix_valid), .pix_in(pix_in), .pix_valid_out(pix_valid_out),
    .pix_out(pix_out)
);

// File: tb/test_gamma_lut.sv
`timescale 1ns/1ps
// Bench: loads every table entry, sweeps every index through all channels and
// checks the port and datapath corner cases against an arithmetic model.
module test_gamma_lut;

    localparam int NCH   = 3;
    localparam int CW    = 8;
    localparam int DEPTH = 2304;
    localparam int PW    = NCH * 3 * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic          reg_sel = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NCH-1:0] gamma_en = '0;
    logic [NCH-1:0] pix_valid = '0;
    logic [PW-1:0]  pix_in = '0;
    logic [NCH-1:0] pix_valid_out;
    logic [PW-1:0]  pix_out;

    int total = 0;
    int bad = 0;
    logic [7:0] model [DEPTH];

    gamma_lut i_gamma_lut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_in(pix_in),
        .pix_valid_out(pix_valid_out), .pix_out(pix_out)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    function automatic logic [PW-1:0] make_pix(input int i, input int mode);
        logic [PW-1:0] v;
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 3; k++)
                v[(c*3+k)*CW +: CW] = (mode == 0) ? 8'((i + c*85 + k*29) % 256)
                                                  : 8'((i*7 + c*3 + k*101) % 256);
        return v;
    endfunction

    function automatic logic [PW-1:0] expect_pix(input logic [PW-1:0] px, input logic [NCH-1:0] en);
        logic [PW-1:0] v;
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 3; k++) begin
                int idx;
                idx = int'(px[(c*3+k)*CW +: CW]);
                v[(c*3+k)*CW +: CW] = en[c] ? model[c*768 + k*256 + idx] : 8'(idx);
            end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One register access: strobe held across one rising edge, read value sampled before it.
    task automatic access(input bit wr, input bit sel, input logic [15:0] wd, output logic [15:0] rv);
        @(negedge clk);
        reg_wr = wr; reg_rd = !wr; reg_sel = sel; reg_wdata = wd;
        #1 rv = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic lookup(input logic [PW-1:0] px, input logic [NCH-1:0] vld);
        @(negedge clk);
        pix_in = px; pix_valid = vld;
        @(negedge clk);
        pix_valid = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] rv;
        logic [PW-1:0] px;
        logic [PW-1:0] ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(pix_valid_out == '0, "R1 valid", PW'(pix_valid_out), '0);
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h0000, "R1 pointer", PW'(rv), PW'(16'h0000));

        // R10: field layout of the pointer register
        access(1'b1, 1'b0, 16'h7ABC, rv);
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h0ABC, "R10 dropped bits", PW'(rv), PW'(16'h0ABC));
        access(1'b1, 1'b0, 16'h8005, rv);
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h8005, "R10 step flag", PW'(rv), PW'(16'h8005));

        // R3 / R2: stream the whole table with stepping writes
        access(1'b1, 1'b0, 16'h8000, rv);
        for (int a = 0; a < DEPTH; a++) begin
            access(1'b1, 1'b1, {8'h00, fill_val(a)}, rv);
            model[a] = fill_val(a);
        end
        // R9: the pointer wrapped after the last entry
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h8000, "R9 wrap after load", PW'(rv), PW'(16'h8000));

        // R5: stepping readback of every entry
        for (int a = 0; a < DEPTH; a++) begin
            access(1'b0, 1'b1, '0, rv);
            check(rv == {8'h00, model[a]}, "R5 stepping read", PW'(rv), PW'({8'h00, model[a]}));
        end
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h8000, "R9 wrap after read", PW'(rv), PW'(16'h8000));

        // R3: single stepping write moves the pointer by one
        access(1'b1, 1'b0, 16'h8020, rv);
        access(1'b1, 1'b1, {8'h00, model[32]}, rv);
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h8021, "R3 step", PW'(rv), PW'(16'h8021));

        // R4 / R5: non-stepping write and read keep the pointer
        access(1'b1, 1'b0, 16'h0010, rv);
        access(1'b1, 1'b1, 16'h005A, rv);
        model[16] = 8'h5A;
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h0010, "R4 pointer held", PW'(rv), PW'(16'h0010));
        access(1'b0, 1'b1, '0, rv);
        check(rv == 16'h005A, "R4 stored value", PW'(rv), PW'(16'h005A));
        access(1'b0, 1'b0, '0, rv);
        check(rv == 16'h0010, "R5 read no step", PW'(rv), PW'(16'h0010));

        // R12: out-of-range pointer stores nothing and reads zero
        access(1'b1, 1'b0, 16'h0900, rv);
        access(1'b1, 1'b1, 16'h00FF, rv);
        access(1'b0, 1'b1, '0, rv);
        check(rv == 16'h0000, "R12 read zero", PW'(rv), '0);
        access(1'b1, 1'b0, 16'h0000, rv);
        access(1'b0, 1'b1, '0, rv);
        check(rv == {8'h00, model[0]}, "R12 entry 0 untouched", PW'(rv), PW'({8'h00, model[0]}));

        // R6 / R2: full index sweep with all channels enabled
        gamma_en = 3'b111;
        for (int i = 0; i < 256; i++) begin
            px = make_pix(i, 0);
            lookup(px, 3'b111);
            ex = expect_pix(px, 3'b111);
            check(pix_out == ex && pix_valid_out == 3'b111, "R6 lookup", pix_out, ex);
        end

        // R7: channel 1 bypassed, the others still mapped
        gamma_en = 3'b101;
        for (int i = 0; i < 256; i++) begin
            px = make_pix(i, 1);
            lookup(px, 3'b111);
            ex = expect_pix(px, 3'b101);
            check(pix_out == ex, "R7 bypass", pix_out, ex);
        end

        // R11: outputs hold while valid is low
        gamma_en = 3'b111;
        ex = pix_out;
        @(negedge clk);
        pix_in = make_pix(77, 0);
        repeat (2) @(negedge clk);
        check(pix_out == ex && pix_valid_out == '0, "R11 hold", pix_out, ex);

        // R8: write and lookup to the same entry in one cycle
        access(1'b1, 1'b0, 16'h0007, rv);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h00C3;
        px = '0; px[7:0] = 8'd7;
        pix_in = px; pix_valid = 3'b001;
        @(negedge clk);
        reg_wr = 1'b0; pix_valid = '0;
        check(pix_out[7:0] == model[7], "R8 old value", PW'(pix_out[7:0]), PW'(model[7]));
        model[7] = 8'hC3;
        lookup(px, 3'b001);
        check(pix_out[7:0] == 8'hC3, "R8 new value", PW'(pix_out[7:0]), PW'(8'hC3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule